// File: doc/BRIEF.md
# Device Configuration Register with Channel Broadcast

This block is a single 32-bit device-level control word that sits next to a group of serial channels. It holds four kinds of content:

- a per-channel sleep-enable field;
- a broadcast control bit;
- three host-driven lines for a serial EEPROM, plus a sampled return line from it;
- two fixed identification bytes, a revision code and a device code.

The host writes the word through a simple register port. The block returns a registered read image of it every cycle.

The broadcast bit changes how the host's channel configuration writes reach the channels. With it clear, a configuration write raises only the addressed channel's write enable. With it set, one write raises every channel's enable in the same cycle, so all channels can be initialised together. Reads of channel configuration always select only the addressed channel, whatever the broadcast setting.

The EEPROM lines are bit-banged by software. The block only holds the three output levels and synchronises the returning data line. The EEPROM protocol itself is left to software.

Top module: `gcfg_reg`

## Requirements
- R1: Read bits 7:0 always return the revision code REV (default 0x01); host writes to these bits have no effect.
- R2: Read bits 15:8 always return the device code {FAMILY, channel count} (default 0x24: family 2, 4 channels); host writes to these bits have no effect.
- R3: Bit 16 is the broadcast control. It is read/write, resets to 0, and reads back the value last written.
- R4: Bits 19:17 are reserved. They read 0, and writing ones to them changes no output and no read bit.
- R5: Bits 20, 21 and 22 of a host write set the `ee_clk`, `ee_cs` and `ee_di` outputs respectively. The outputs take the new level on the clock edge that accepts the write, and all three are 0 after reset.
- R6: Bits 20, 21 and 22 are write-only and always read 0.
- R7: Bit 23 returns the `ee_do` input through a two-flop synchronizer. A level change appears in the read word three clock edges after it is applied, and not after two.
- R8: Bits 31:24 are the sleep field. The low NCH bits are read/write, reset to 0 and drive `sleep_en`. The bits above NCH read 0.
- R9: With broadcast clear, a `cfg_wr` pulse raises only bit `cfg_ch` of `cfg_we`, for exactly one cycle, on the edge after the request. Without `cfg_wr`, `cfg_we` is 0.
- R10: With broadcast set, a `cfg_wr` pulse raises every bit of `cfg_we` for one cycle, whatever `cfg_ch` is.
- R11: A `cfg_rd` pulse raises only bit `cfg_ch` of `cfg_rd_sel` for one cycle, whether broadcast is set or clear.
- R12: `rdata` shows the result of a host write one clock edge after the fields change. On the edge that accepts the write, `rdata` still shows the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the device word |
| reg_wdata | input | 32 | Write data for the device word |
| rdata | output | 32 | Registered read image of the device word |
| cfg_wr | input | 1 | Channel configuration write request |
| cfg_rd | input | 1 | Channel configuration read request |
| cfg_ch | input | CW | Addressed channel of the request |
| cfg_we | output | NCH | Per-channel configuration write enables |
| cfg_rd_sel | output | NCH | One-hot channel read select |
| sleep_en | output | NCH | Per-channel sleep enables |
| ee_clk | output | 1 | EEPROM clock line |
| ee_cs | output | 1 | EEPROM chip-select line |
| ee_di | output | 1 | EEPROM data line into the memory |
| ee_do | input | 1 | EEPROM data line out of the memory, asynchronous |

## Verification
The bench builds the block with its defaults: four channels, family 2 and revision 1. With these values the expected identification word is 0x2401, and the sleep field has four live bits and four reserved bits. Four channels let the bench sweep every `cfg_ch` value in individual mode and then check that the same requests produce an all-ones enable once broadcast is set. Each test drives the asynchronous `ee_do` line and samples the read word edge by edge, so the exact synchronizer delay can be checked.

// File: rtl/gcfg_pkg.sv
package gcfg_pkg;
  localparam int REV_LSB   = 0;
  localparam int ID_LSB    = 8;
  localparam int BCAST_BIT = 16;
  localparam int ECLK_BIT  = 20;
  localparam int ECS_BIT   = 21;
  localparam int EDI_BIT   = 22;
  localparam int EDO_BIT   = 23;
  localparam int SLP_LSB   = 24;
  localparam int SLP_W     = 8;

  typedef struct packed {
    logic ee_di;
    logic ee_cs;
    logic ee_clk;
    logic bcast;
  } gcfg_ctl_t;
endpackage

// File: rtl/gcfg_sync.sv
module gcfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gcfg_fanout.sv
module gcfg_fanout #(
  parameter int NCH = 4,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bcast,
  input  logic           cfg_wr,
  input  logic           cfg_rd,
  input  logic [CW-1:0]  cfg_ch,
  output logic [NCH-1:0] cfg_we,
  output logic [NCH-1:0] cfg_rd_sel
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = (cfg_ch == CW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_we[i]     <= 1'b0;
        cfg_rd_sel[i] <= 1'b0;
      end else begin
        cfg_we[i]     <= cfg_wr & (bcast | hit);
        cfg_rd_sel[i] <= cfg_rd & hit;
      end
    end
  end
endmodule

// File: rtl/gcfg_reg.sv
module gcfg_reg
  import gcfg_pkg::*;
#(
  parameter int         NCH    = 4,
  parameter logic [3:0] FAMILY = 4'h2,
  parameter logic [7:0] REV    = 8'h01,
  parameter int         SYNC_N = 2,
  parameter int         CW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    rdata,
  input  logic           cfg_wr,
  input  logic           cfg_rd,
  input  logic [CW-1:0]  cfg_ch,
  output logic [NCH-1:0] cfg_we,
  output logic [NCH-1:0] cfg_rd_sel,
  output logic [NCH-1:0] sleep_en,
  output logic           ee_clk,
  output logic           ee_cs,
  output logic           ee_di,
  input  logic           ee_do
);
  localparam logic [7:0] DEV_ID = {FAMILY, 4'(NCH)};

  gcfg_ctl_t      ctl_q;
  logic [NCH-1:0] sleep_q;
  logic           edo_s;
  logic [SLP_W-1:0] slp_ext;
  logic [31:0]    rd_img;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      sleep_q <= '0;
    end else if (reg_wr) begin
      ctl_q.bcast  <= reg_wdata[BCAST_BIT];
      ctl_q.ee_clk <= reg_wdata[ECLK_BIT];
      ctl_q.ee_cs  <= reg_wdata[ECS_BIT];
      ctl_q.ee_di  <= reg_wdata[EDI_BIT];
      sleep_q      <= reg_wdata[SLP_LSB +: NCH];
    end
  end

  gcfg_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d(ee_do), .q(edo_s)
  );

  gcfg_fanout #(.NCH(NCH), .CW(CW)) u_fan (
    .clk(clk), .rst(rst), .bcast(ctl_q.bcast),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_ch(cfg_ch),
    .cfg_we(cfg_we), .cfg_rd_sel(cfg_rd_sel)
  );

  always_comb begin
    slp_ext = '0;
    slp_ext[NCH-1:0] = sleep_q;
    rd_img = '0;
    rd_img[REV_LSB +: 8]   = REV;
    rd_img[ID_LSB +: 8]    = DEV_ID;
    rd_img[BCAST_BIT]      = ctl_q.bcast;
    rd_img[EDO_BIT]        = edo_s;
    rd_img[SLP_LSB +: SLP_W] = slp_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= {16'h0000, DEV_ID, REV};
    else     rdata <= rd_img;
  end

  assign sleep_en = sleep_q;
  assign ee_clk   = ctl_q.ee_clk;
  assign ee_cs    = ctl_q.ee_cs;
  assign ee_di    = ctl_q.ee_di;
endmodule

// File: rtl/gcfg_chk.sv
module gcfg_chk #(
  parameter int         NCH    = 4,
  parameter logic [3:0] FAMILY = 4'h2,
  parameter logic [7:0] REV    = 8'h01,
  parameter int         CW     = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           reg_wr,
  input logic [31:0]    reg_wdata,
  input logic [31:0]    rdata,
  input logic           cfg_wr,
  input logic           cfg_rd,
  input logic [CW-1:0]  cfg_ch,
  input logic [NCH-1:0] cfg_we,
  input logic [NCH-1:0] cfg_rd_sel,
  input logic           ee_clk,
  input logic           bcast
);
  AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst) !rst |=> rdata[15:0] == {FAMILY, 4'(NCH), REV}); // R2
  AST_WO_ZERO: assert property (@(posedge clk) disable iff (rst) !rst |=> rdata[22:17] == 6'd0); // R6
  AST_ECLK_WR: assert property (@(posedge clk) disable iff (rst) reg_wr |=> ee_clk == $past(reg_wdata[20])); // R5
  AST_WE_ONE: assert property (@(posedge clk) disable iff (rst) (cfg_wr && !bcast) |=> $countones(cfg_we) == 1); // R9
  AST_WE_IDLE: assert property (@(posedge clk) disable iff (rst) !cfg_wr |=> cfg_we == '0); // R9
  AST_WE_ALL: assert property (@(posedge clk) disable iff (rst) (cfg_wr && bcast) |=> &cfg_we); // R10
  AST_RD_ONE: assert property (@(posedge clk) disable iff (rst) cfg_rd |=> $countones(cfg_rd_sel) == 1); // R11
endmodule

bind gcfg_reg gcfg_chk #(.NCH(NCH), .FAMILY(FAMILY), .REV(REV), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .rdata(rdata),
  .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_ch(cfg_ch), .cfg_we(cfg_we),
  .cfg_rd_sel(cfg_rd_sel), .ee_clk(ee_clk), .bcast(ctl_q.bcast)
);

// File: tb/sim_gcfg_reg.sv
module sim_gcfg_reg;
  logic        clk = 0;
  logic        rst = 1;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata;
  logic        cfg_wr = 0, cfg_rd = 0;
  logic [1:0]  cfg_ch = '0;
  logic [3:0]  cfg_we, cfg_rd_sel, sleep_en;
  logic        ee_clk, ee_cs, ee_di;
  logic        ee_do = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gcfg_reg u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .rdata(rdata),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_ch(cfg_ch), .cfg_we(cfg_we),
    .cfg_rd_sel(cfg_rd_sel), .sleep_en(sleep_en), .ee_clk(ee_clk), .ee_cs(ee_cs),
    .ee_di(ee_di), .ee_do(ee_do)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic t_reset;
    chk("R1 R2 reset word", rdata, 32'h0000_2401);
    chk("R5 reset ee lines", {29'd0, ee_di, ee_cs, ee_clk}, 32'd0);
    chk("R8 reset sleep", {28'd0, sleep_en}, 32'd0);
    chk("R9 reset we", {28'd0, cfg_we}, 32'd0);
  endtask

  task automatic t_ro_fields;
    wr(32'h000E_FFFF);
    @(negedge clk);
    chk("R1 R2 R4 writes ignored", rdata, 32'h0000_2401);
    chk("R4 no output change", {24'd0, sleep_en, 1'b0, ee_di, ee_cs, ee_clk}, 32'd0);
  endtask

  task automatic t_eeprom;
    wr(32'h0010_0000);
    chk("R5 ee_clk set", {29'd0, ee_di, ee_cs, ee_clk}, 32'd1);
    @(negedge clk);
    chk("R6 ee_clk reads 0", rdata, 32'h0000_2401);
    wr(32'h0060_0000);
    chk("R5 cs/di set", {29'd0, ee_di, ee_cs, ee_clk}, 32'd6);
    @(negedge clk);
    chk("R6 cs/di read 0", rdata, 32'h0000_2401);
    wr(32'h0000_0000);
  endtask

  task automatic t_edo;
    @(negedge clk); ee_do = 1;
    @(negedge clk); @(negedge clk);
    chk("R7 not after two edges", {31'd0, rdata[23]}, 32'd0);
    @(negedge clk);
    chk("R7 after three edges", {31'd0, rdata[23]}, 32'd1);
    ee_do = 0;
    repeat (3) @(negedge clk);
    chk("R7 falls back", {31'd0, rdata[23]}, 32'd0);
  endtask

  task automatic t_sleep;
    wr(32'hA500_0000);
    chk("R8 sleep_en", {28'd0, sleep_en}, 32'd5);
    chk("R12 rdata still old", rdata, 32'h0000_2401);
    @(negedge clk);
    chk("R8 R12 sleep readback", rdata, 32'h0500_2401);
    wr(32'h0000_0000);
  endtask

  task automatic t_cfg_single;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); cfg_wr = 1; cfg_ch = 2'(c);
      @(negedge clk); cfg_wr = 0;
      chk("R9 one enable", {28'd0, cfg_we}, 32'(1 << c));
      @(negedge clk);
      chk("R9 one cycle", {28'd0, cfg_we}, 32'd0);
    end
  endtask

  task automatic t_bcast;
    wr(32'h0001_0000);
    @(negedge clk);
    chk("R3 bcast readback", rdata, 32'h0001_2401);
    for (int c = 0; c < 4; c += 3) begin
      @(negedge clk); cfg_wr = 1; cfg_ch = 2'(c);
      @(negedge clk); cfg_wr = 0;
      chk("R10 all enables", {28'd0, cfg_we}, 32'hF);
      @(negedge clk);
      chk("R10 one cycle", {28'd0, cfg_we}, 32'd0);
    end
    @(negedge clk); cfg_rd = 1; cfg_ch = 2'd2;
    @(negedge clk); cfg_rd = 0;
    chk("R11 read select in broadcast", {28'd0, cfg_rd_sel}, 32'd4);
    chk("R11 no write enable", {28'd0, cfg_we}, 32'd0);
    wr(32'h0000_0000);
    @(negedge clk);
    chk("R3 bcast cleared", {31'd0, rdata[16]}, 32'd0);
    @(negedge clk); cfg_rd = 1; cfg_ch = 2'd1;
    @(negedge clk); cfg_rd = 0;
    chk("R11 read select individual", {28'd0, cfg_rd_sel}, 32'd2);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_ro_fields();
    t_eeprom();
    t_edo();
    t_sleep();
    t_cfg_single();
    t_bcast();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end
endmodule